// File: doc/BRIEF.md
# Frame Header Error Flag Checker

This block watches the header and frame events of a time-triggered communication controller and records four kinds of protocol fault in sticky flags. On each header write it compares the header's payload length with the configured settings. A transmit buffer in the static segment must carry exactly the configured static length. A receive buffer in the static segment must be at least as long as the configured network-management length. On each received frame it rejects a static-segment frame that claims both a management preamble and a null payload. A strobe from the memory subsystem records an illegal memory access made by the controller.

Checks run only on their qualifying strobe and never continuously. Software reads the flags and clears any of them by writing 1 to the bit. Each flag has its own enable bit. The interrupt request is high while any enabled flag is set. A parameter chooses whether the request comes straight from the flag registers or passes through one more register stage.

Top module: `hdr_err_flags`

## Requirements
- R1: On a header-write strobe for a transmit buffer in the static segment whose length differs from `cfg_static_len`, flag bit 3 is set after the next clock edge.
- R2: On a header-write strobe for a receive buffer in the static segment whose length is strictly less than `cfg_nm_len`, flag bit 2 is set after the next clock edge. A length equal to `cfg_nm_len` sets nothing.
- R3: On a frame-received strobe for a static-segment frame with both the preamble indicator and the null indicator high, flag bit 1 is set after the next clock edge.
- R4: A memory-error strobe sets flag bit 0 after the next clock edge.
- R5: Flags are sticky. A clear write (`clr_wr` high) clears each flag whose `clr_data` bit is 1 and leaves flags whose `clr_data` bit is 0 unchanged.
- R6: When a flag's set condition and its clear bit occur in the same cycle, the flag is set after that edge.
- R7: No flag changes without its qualifying strobe. A dynamic-segment header or frame, a preamble-only frame, a null-only frame and a matching length all leave the flags unchanged.
- R8: `en_wr` loads `en_data` into the enable register (bit order as the flags). In the default variant, `irq` is high exactly while some flag and its enable bit are both 1.
- R9: After reset all flags, all enables and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_wr_stb | input | 1 | Header written, qualifies the length checks |
| hdr_is_tx | input | 1 | 1 = transmit buffer, 0 = receive buffer |
| hdr_is_static | input | 1 | Buffer assigned to the static segment |
| hdr_len | input | LEN_W | Payload length in the header |
| cfg_static_len | input | LEN_W | Configured static-segment payload length |
| cfg_nm_len | input | LEN_W | Configured network-management vector length |
| rx_stb | input | 1 | Frame received, qualifies the indicator check |
| rx_is_static | input | 1 | Frame received in the static segment |
| rx_preamble | input | 1 | Preamble indicator of the received frame |
| rx_null | input | 1 | Null-frame indicator of the received frame |
| mem_err_stb | input | 1 | Illegal memory access reported by the memory subsystem |
| clr_wr | input | 1 | Write-1-to-clear strobe for the flags |
| clr_data | input | 4 | Clear mask, bit order as `err_flags` |
| en_wr | input | 1 | Enable register write strobe |
| en_data | input | 4 | New enable value |
| err_flags | output | 4 | Bit 3 static length, 2 NM length, 1 NM frame, 0 illegal access |
| err_en | output | 4 | Current enable bits |
| irq | output | 1 | Interrupt request |

## Verification
A flag's set event and a software clear of the same bit can fall in the same cycle. The bench provokes this by raising the memory-error strobe and a clear write for bit 0 in one cycle. It judges the result correct only if bit 0 reads 1 after that edge. It repeats the case with a static-length mismatch on bit 3, and also clears a neighbouring bit in the same write to confirm that only the colliding bit survives.

// File: rtl/hdr_err_pkg.sv
package hdr_err_pkg;
   localparam int unsigned FLAG_N  = 4;
   localparam int unsigned IDX_SPL = 3;  // static payload length mismatch
   localparam int unsigned IDX_NML = 2;  // management length shortfall
   localparam int unsigned IDX_NMF = 1;  // preamble with null payload
   localparam int unsigned IDX_MEM = 0;  // illegal memory access

   typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/hdr_err_detect.sv
module hdr_err_detect
   import hdr_err_pkg::*;
#(
   parameter int unsigned LEN_W = 7
) (
   input  logic             hdr_wr_stb,
   input  logic             hdr_is_tx,
   input  logic             hdr_is_static,
   input  logic [LEN_W-1:0] hdr_len,
   input  logic [LEN_W-1:0] cfg_static_len,
   input  logic [LEN_W-1:0] cfg_nm_len,
   input  logic             rx_stb,
   input  logic             rx_is_static,
   input  logic             rx_preamble,
   input  logic             rx_null,
   input  logic             mem_err_stb,
   output flag_vec_t        set_vec
);
   logic hdr_static_q;
   logic len_mismatch;
   logic len_short;

   always_comb begin
      hdr_static_q = hdr_wr_stb && hdr_is_static;
      len_mismatch = hdr_len != cfg_static_len;
      len_short    = hdr_len < cfg_nm_len;
      set_vec          = '0;
      set_vec[IDX_SPL] = hdr_static_q && hdr_is_tx && len_mismatch;
      set_vec[IDX_NML] = hdr_static_q && !hdr_is_tx && len_short;
      set_vec[IDX_NMF] = rx_stb && rx_is_static && rx_preamble && rx_null;
      set_vec[IDX_MEM] = mem_err_stb;
   end
endmodule

// File: rtl/hdr_err_flag_cell.sv
module hdr_err_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end

   // R5: a set flag with no clear request stays set
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      q && !clr_i |=> q);
   // R5: a clear request without a set event drops the flag
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !set_i |=> !q);
   // R6: set wins over a simultaneous clear
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i && clr_i |=> q);
   // R7: the flag never rises without its set event
   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !set_i |=> !$rose(q));
endmodule

// File: rtl/hdr_err_irq.sv
module hdr_err_irq
   import hdr_err_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  flag_vec_t flags,
   input  flag_vec_t enables,
   output logic      irq
);
   logic pend;

   always_comb pend = |(flags & enables);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = pend;
      // R8: the request needs at least one enable and one flag
      a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> |enables);
      a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> |flags);
   end
endmodule

// File: rtl/hdr_err_flags.sv
module hdr_err_flags
   import hdr_err_pkg::*;
#(
   parameter int unsigned LEN_W   = 7,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_wr_stb,
   input  logic              hdr_is_tx,
   input  logic              hdr_is_static,
   input  logic [LEN_W-1:0]  hdr_len,
   input  logic [LEN_W-1:0]  cfg_static_len,
   input  logic [LEN_W-1:0]  cfg_nm_len,
   input  logic              rx_stb,
   input  logic              rx_is_static,
   input  logic              rx_preamble,
   input  logic              rx_null,
   input  logic              mem_err_stb,
   input  logic              clr_wr,
   input  logic [FLAG_N-1:0] clr_data,
   input  logic              en_wr,
   input  logic [FLAG_N-1:0] en_data,
   output logic [FLAG_N-1:0] err_flags,
   output logic [FLAG_N-1:0] err_en,
   output logic              irq
);
   initial begin
      a_len_w_range: assert (LEN_W >= 1 && LEN_W <= 16)
         else $error("LEN_W out of range: %0d", LEN_W);
   end

   flag_vec_t set_vec;
   flag_vec_t flag_q;
   flag_vec_t en_q;

   hdr_err_detect #(.LEN_W(LEN_W)) u_detect (
      .hdr_wr_stb    (hdr_wr_stb),
      .hdr_is_tx     (hdr_is_tx),
      .hdr_is_static (hdr_is_static),
      .hdr_len       (hdr_len),
      .cfg_static_len(cfg_static_len),
      .cfg_nm_len    (cfg_nm_len),
      .rx_stb        (rx_stb),
      .rx_is_static  (rx_is_static),
      .rx_preamble   (rx_preamble),
      .rx_null       (rx_null),
      .mem_err_stb   (mem_err_stb),
      .set_vec       (set_vec)
   );

   for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
      hdr_err_flag_cell u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .set_i(set_vec[gi]),
         .clr_i(clr_wr && clr_data[gi]),
         .q    (flag_q[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_wr) en_q <= en_data;
   end

   hdr_err_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags  (flag_q),
      .enables(en_q),
      .irq    (irq)
   );

   assign err_flags = flag_q;
   assign err_en    = en_q;

   // R1: static transmit header with wrong length raises bit 3
   a_r1_static_len: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_wr_stb && hdr_is_tx && hdr_is_static && (hdr_len != cfg_static_len)
      |=> err_flags[IDX_SPL]);
   // R2: static receive header shorter than the management length raises bit 2
   a_r2_nm_len: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_wr_stb && !hdr_is_tx && hdr_is_static && (hdr_len < cfg_nm_len)
      |=> err_flags[IDX_NML]);
   // R3: preamble together with null payload raises bit 1
   a_r3_nm_frame: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb && rx_is_static && rx_preamble && rx_null |=> err_flags[IDX_NMF]);
   // R4: memory error strobe raises bit 0
   a_r4_mem: assert property (@(posedge clk) disable iff (!rst_n)
      mem_err_stb |=> err_flags[IDX_MEM]);
   // R8: the enable register follows a write
   a_r8_en_load: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> err_en == $past(en_data));
   a_r8_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(err_en));
endmodule

// File: tb/test_hdr_err_flags.sv
module test_hdr_err_flags;
   localparam int CLK_P = 10;
   localparam int LW    = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hdr_wr_stb = 0, hdr_is_tx = 0, hdr_is_static = 0;
   logic [LW-1:0] hdr_len = '0, cfg_static_len = '0, cfg_nm_len = '0;
   logic          rx_stb = 0, rx_is_static = 0, rx_preamble = 0, rx_null = 0;
   logic          mem_err_stb = 0, clr_wr = 0, en_wr = 0;
   logic [3:0]    clr_data = '0, en_data = '0;
   logic [3:0]    err_flags, err_en;
   logic          irq;

   int total = 0;
   int bad   = 0;

   always #(CLK_P/2) clk = ~clk;

   hdr_err_flags #(.LEN_W(LW)) i_hdr_err_flags (
      .clk(clk), .rst_n(rst_n),
      .hdr_wr_stb(hdr_wr_stb), .hdr_is_tx(hdr_is_tx), .hdr_is_static(hdr_is_static),
      .hdr_len(hdr_len), .cfg_static_len(cfg_static_len), .cfg_nm_len(cfg_nm_len),
      .rx_stb(rx_stb), .rx_is_static(rx_is_static), .rx_preamble(rx_preamble),
      .rx_null(rx_null), .mem_err_stb(mem_err_stb),
      .clr_wr(clr_wr), .clr_data(clr_data), .en_wr(en_wr), .en_data(en_data),
      .err_flags(err_flags), .err_en(err_en), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // inputs change at negedge; one posedge passes; sample at the following negedge
   task automatic step();
      @(negedge clk);
      hdr_wr_stb = 0; rx_stb = 0; mem_err_stb = 0; clr_wr = 0; en_wr = 0;
   endtask

   task automatic hdr(input logic tx, input logic st, input int len);
      hdr_wr_stb = 1; hdr_is_tx = tx; hdr_is_static = st; hdr_len = LW'(len);
      step();
   endtask

   task automatic frame(input logic st, input logic pre, input logic nul);
      rx_stb = 1; rx_is_static = st; rx_preamble = pre; rx_null = nul;
      step();
   endtask

   task automatic clear(input logic [3:0] m);
      clr_wr = 1; clr_data = m;
      step();
   endtask

   task automatic t_reset();
      check("R9 flags", err_flags, 0);
      check("R9 enables", err_en, 0);
      check("R9 irq", irq, 0);
   endtask

   task automatic t_static_len();
      cfg_static_len = 20;
      hdr(1, 1, 20);
      check("R7 matching static length", err_flags, 4'b0000);
      hdr(1, 0, 5);
      check("R7 dynamic tx header", err_flags, 4'b0000);
      hdr_is_tx = 1; hdr_is_static = 1; hdr_len = 33;
      step();
      check("R7 no strobe", err_flags, 4'b0000);
      hdr(1, 1, 21);
      check("R1 length mismatch", err_flags, 4'b1000);
      clear(4'b1111);
      hdr(1, 1, 0);
      check("R1 zero length mismatch", err_flags, 4'b1000);
      clear(4'b1111);
   endtask

   task automatic t_nm_len();
      cfg_nm_len = 8;
      hdr(0, 1, 8);
      check("R2 equal length no flag", err_flags, 4'b0000);
      hdr(0, 0, 2);
      check("R7 dynamic rx header", err_flags, 4'b0000);
      hdr(0, 1, 7);
      check("R2 shortfall", err_flags, 4'b0100);
      clear(4'b0100);
      check("R5 cleared", err_flags, 4'b0000);
   endtask

   task automatic t_nm_frame();
      frame(1, 1, 0);
      check("R7 preamble only", err_flags, 4'b0000);
      frame(1, 0, 1);
      check("R7 null only", err_flags, 4'b0000);
      frame(0, 1, 1);
      check("R7 dynamic frame", err_flags, 4'b0000);
      frame(1, 1, 1);
      check("R3 preamble with null", err_flags, 4'b0010);
      clear(4'b1111);
   endtask

   task automatic t_mem();
      mem_err_stb = 1;
      step();
      check("R4 memory error", err_flags, 4'b0001);
      step();
      check("R5 sticky after strobe", err_flags, 4'b0001);
      clear(4'b1111);
   endtask

   task automatic t_sticky_clear();
      cfg_static_len = 10; cfg_nm_len = 8;
      hdr(1, 1, 11);
      hdr(0, 1, 3);
      frame(1, 1, 1);
      mem_err_stb = 1; step();
      check("R5 all set", err_flags, 4'b1111);
      clear(4'b0000);
      check("R5 zero mask no effect", err_flags, 4'b1111);
      clear(4'b0101);
      check("R5 partial clear", err_flags, 4'b1010);
      clear(4'b1111);
   endtask

   task automatic t_set_vs_clear();
      mem_err_stb = 1; clr_wr = 1; clr_data = 4'b0001;
      step();
      check("R6 set beats clear bit0", err_flags, 4'b0001);
      cfg_static_len = 10;
      hdr_wr_stb = 1; hdr_is_tx = 1; hdr_is_static = 1; hdr_len = 12;
      clr_wr = 1; clr_data = 4'b1001;
      step();
      check("R6 set beats clear bit3, bit0 cleared", err_flags, 4'b1000);
      clear(4'b1111);
   endtask

   task automatic t_irq();
      frame(1, 1, 1);
      en_wr = 1; en_data = 4'b0100; step();
      check("R8 enable readback", err_en, 4'b0100);
      check("R8 irq masked", irq, 0);
      en_wr = 1; en_data = 4'b0110; step();
      check("R8 irq raised", irq, 1);
      clear(4'b0010);
      check("R8 irq drops with flag", irq, 0);
      mem_err_stb = 1; step();
      check("R8 flag without enable", irq, 0);
      en_wr = 1; en_data = 4'b0001; step();
      check("R8 irq after enable", irq, 1);
   endtask

   initial begin
      #(CLK_P * 20000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_static_len();
      t_nm_len();
      t_nm_frame();
      t_mem();
      t_sticky_clear();
      t_set_vs_clear();
      t_irq();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule